// File: doc/BRIEF.md
# Split-Half Masked GPIO Register Front End

This block is the register front end of a 32-pin general-purpose I/O bank. It sits on a small valid/ready register bus and holds the pin output-value and pin direction registers. It also returns a synchronized copy of the pin input levels and a fixed identification word. Interrupt detection, debounce filtering and the pad drivers are outside this block.

Each 32-bit logical register occupies two word addresses, and each address holds 16 bits. A write word carries 16 data bits in its low half and 16 per-bit write enables in its high half. Software can therefore set or clear any single pin with one write and no read-modify-write cycle. The stored output-value and direction bits drive the pad logic directly.

Top module: `gpio_regif`

## Requirements
- R1: On a write, bits 15:0 of the bus word are data and bits 31:16 are the write enables. A stored bit takes its data bit only where the matching enable is 1; every other stored bit keeps its value. Data 1 sets the bit and data 0 clears it.
- R2: Bits 15:0 of a logical register are written at its base address and bits 31:16 at base+4. Pin n uses data bit n%16 and enable bit n%16+16 of the half that n≥16 selects.
- R3: A read of either half returns that half's 16 stored bits in bits 15:0, with bits 31:16 zero.
- R4: The output-value register sits at 0x00/0x04 and drives `pin_out`. The direction register sits at 0x08/0x0C and drives `pin_oe`, where 1 means output.
- R5: A read of 0x78 returns the identification word 0x01000C2B.
- R6: A read of 0x70 returns all 32 pin levels as one unsplit word, sampled through a two-flop synchronizer. A level held for three clock edges is visible to a read.
- R7: A read of an unmapped address returns 0, and a write to one leaves every register unchanged.
- R8: Writes to 0x70 and 0x78 change nothing.
- R9: A synchronous reset clears every stored register, so `pin_out` and `pin_oe` are 0 and `rsp_valid` is 0.
- R10: `req_ready` is always 1. An accepted read gives `rsp_valid` high for exactly the following cycle, with the data on `rsp_rdata`. A write gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write word: enables 31:16, data 15:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables (1 = drive) |

## Verification
The bench builds the block with its default parameters: 16-bit halves forming a 32-pin bank, an 8-bit address, two synchronizer stages and the default identification word. With these values, a bit at each end of each half can be addressed, so pins 0, 15, 16 and 31 all fall within a handful of writes. The synchronizer latency is short enough to check a pin change against a read issued a few cycles later. The whole address map, including unmapped holes and the read-only words, is reachable within an 8-bit address space.

// File: rtl/gpio_regif_pkg.sv
package gpio_regif_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DOUT = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EXT  = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_VER  = 8'h78;
    localparam logic [ADDR_W-1:0] HI_STEP  = 8'h04;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DOUT_LO,
        SEL_DOUT_HI,
        SEL_DIR_LO,
        SEL_DIR_HI,
        SEL_EXT,
        SEL_VER
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [HALF_W-1:0] data;
        logic [HALF_W-1:0] en;
    } half_wr_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a == OFS_DOUT)                s = SEL_DOUT_LO;
        else if (a == OFS_DOUT + HI_STEP) s = SEL_DOUT_HI;
        else if (a == OFS_DIR)            s = SEL_DIR_LO;
        else if (a == OFS_DIR + HI_STEP)  s = SEL_DIR_HI;
        else if (a == OFS_EXT)            s = SEL_EXT;
        else if (a == OFS_VER)            s = SEL_VER;
        else                              s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [HALF_W-1:0] merge_bits(
        input logic [HALF_W-1:0] cur,
        input logic [HALF_W-1:0] dat,
        input logic [HALF_W-1:0] en
    );
        return (cur & ~en) | (dat & en);
    endfunction
endpackage

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg
    import gpio_regif_pkg::*;
#(
    parameter reg_sel_e LO_SEL = SEL_DOUT_LO,
    parameter reg_sel_e HI_SEL = SEL_DOUT_HI
) (
    input  logic              clk,
    input  logic              rst,
    input  half_wr_t          wreq,
    output logic [WORD_W-1:0] q
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam reg_sel_e MY_SEL = (h == 0) ? LO_SEL : HI_SEL;
        logic [HALF_W-1:0] bits;
        always_ff @(posedge clk) begin
            if (rst)
                bits <= '0;
            else if (wreq.wr && wreq.sel == MY_SEL)
                bits <= merge_bits(bits, wreq.data, wreq.en);
        end
        assign q[h*HALF_W +: HALF_W] = bits;
    end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[s] <= '0;
            else if (s == 0)
                stg[s] <= d;
            else
                stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end
    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regif.sv
module gpio_regif
    import gpio_regif_pkg::*;
#(
    parameter logic [WORD_W-1:0] VERSION_WORD = 32'h0100_0C2B,
    parameter int                SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic [WORD_W-1:0] pin_in,
    output logic [WORD_W-1:0] pin_out,
    output logic [WORD_W-1:0] pin_oe
);
    logic              fire;
    reg_sel_e          sel;
    half_wr_t          wreq;
    logic [WORD_W-1:0] ext_lvl;
    logic [WORD_W-1:0] rd_mux;

    assign req_ready = 1'b1;
    assign fire      = req_valid && req_ready;
    assign sel       = decode_addr(req_addr);

    always_comb begin
        wreq.wr   = fire && req_write;
        wreq.sel  = sel;
        wreq.data = req_wdata[HALF_W-1:0];
        wreq.en   = req_wdata[WORD_W-1:HALF_W];
    end

    gpio_masked_reg #(.LO_SEL(SEL_DOUT_LO), .HI_SEL(SEL_DOUT_HI)) u_dout (
        .clk(clk), .rst(rst), .wreq(wreq), .q(pin_out)
    );

    gpio_masked_reg #(.LO_SEL(SEL_DIR_LO), .HI_SEL(SEL_DIR_HI)) u_dir (
        .clk(clk), .rst(rst), .wreq(wreq), .q(pin_oe)
    );

    gpio_pin_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(ext_lvl)
    );

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_DOUT_LO: rd_mux[HALF_W-1:0] = pin_out[HALF_W-1:0];
            SEL_DOUT_HI: rd_mux[HALF_W-1:0] = pin_out[WORD_W-1:HALF_W];
            SEL_DIR_LO:  rd_mux[HALF_W-1:0] = pin_oe[HALF_W-1:0];
            SEL_DIR_HI:  rd_mux[HALF_W-1:0] = pin_oe[WORD_W-1:HALF_W];
            SEL_EXT:     rd_mux = ext_lvl;
            SEL_VER:     rd_mux = VERSION_WORD;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= fire && !req_write;
            rsp_rdata <= (fire && !req_write) ? rd_mux : '0;
        end
    end

    // R1 / R2: low-half write leaves non-enabled bits alone
    assert_masked_lo_R1: assert property (@(posedge clk) disable iff (rst)
        (fire && req_write && req_addr == OFS_DOUT) |=>
        (((pin_out[HALF_W-1:0] ^ $past(pin_out[HALF_W-1:0]))
          & ~$past(req_wdata[WORD_W-1:HALF_W])) == '0));

    // R2: low-half write never touches upper bits
    assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (fire && req_write && req_addr == OFS_DOUT) |=>
        $stable(pin_out[WORD_W-1:HALF_W]));

    // R7 / R8: no write, no register change
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
        !(fire && req_write) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R5: identification word read
    assert_version_R5: assert property (@(posedge clk) disable iff (rst)
        (fire && !req_write && req_addr == OFS_VER) |=> (rsp_rdata == VERSION_WORD));

    // R10: one response per accepted read
    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (fire && !req_write) |=> rsp_valid);
    assert_no_rsp_R10: assert property (@(posedge clk) disable iff (rst)
        !(fire && !req_write) |=> !rsp_valid);

    // R9: reset clears outputs
    assert_reset_clear_R9: assert property (@(posedge clk)
        $past(rst) |-> (pin_out == '0 && pin_oe == '0 && !rsp_valid));
endmodule

// File: tb/gpio_regif_test.sv
module gpio_regif_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata, pin_in, pin_out, pin_oe;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gpio_regif uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] e_out;
        logic [31:0] e_oe;
        logic [31:0] e_rd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 32'hFFFF_A5A5, 32'h0000_A5A5, 32'h0000_0000, 32'h0}, // R1 set
        '{1'b1, 8'h00, 32'h00F0_0000, 32'h0000_A505, 32'h0000_0000, 32'h0}, // R1 clear
        '{1'b1, 8'h04, 32'h8001_8001, 32'h8001_A505, 32'h0000_0000, 32'h0}, // R2 upper
        '{1'b1, 8'h04, 32'h0001_0000, 32'h8000_A505, 32'h0000_0000, 32'h0}, // R2 bit16 clr
        '{1'b0, 8'h04, 32'h0,         32'h8000_A505, 32'h0000_0000, 32'h0000_8000}, // R3
        '{1'b0, 8'h00, 32'h0,         32'h8000_A505, 32'h0000_0000, 32'h0000_A505}, // R3
        '{1'b1, 8'h08, 32'h0003_0002, 32'h8000_A505, 32'h0000_0002, 32'h0}, // R4
        '{1'b1, 8'h0C, 32'hFFFF_1234, 32'h8000_A505, 32'h1234_0002, 32'h0}, // R4
        '{1'b0, 8'h0C, 32'h0,         32'h8000_A505, 32'h1234_0002, 32'h0000_1234}, // R4
        '{1'b0, 8'h78, 32'h0,         32'h8000_A505, 32'h1234_0002, 32'h0100_0C2B}, // R5
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h8000_A505, 32'h1234_0002, 32'h0}, // R7
        '{1'b0, 8'h10, 32'h0,         32'h8000_A505, 32'h1234_0002, 32'h0}, // R7
        '{1'b1, 8'h78, 32'hFFFF_0000, 32'h8000_A505, 32'h1234_0002, 32'h0}, // R8
        '{1'b1, 8'h70, 32'hFFFF_FFFF, 32'h8000_A505, 32'h1234_0002, 32'h0}  // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 pin_out", pin_out, 32'h0);
        check("R9 pin_oe", pin_oe, 32'h0);
        check("R9 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check("R10 ready", {31'b0, req_ready}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i].wr, VEC[i].addr, VEC[i].wdata);
            check($sformatf("vec%0d pin_out", i), pin_out, VEC[i].e_out);
            check($sformatf("vec%0d pin_oe", i), pin_oe, VEC[i].e_oe);
            if (!VEC[i].wr) begin
                check($sformatf("vec%0d R10 rsp_valid", i), {31'b0, rsp_valid}, 32'h1);
                check($sformatf("vec%0d rdata", i), rsp_rdata, VEC[i].e_rd);
            end else begin
                check($sformatf("vec%0d R10 no rsp on write", i), {31'b0, rsp_valid}, 32'h0);
            end
        end

        // R8: read-only words still read as before after writes
        bus_op(1'b0, 8'h78, 32'h0);
        check("R8 version intact", rsp_rdata, 32'h0100_0C2B);
        @(negedge clk);
        check("R10 rsp one cycle", {31'b0, rsp_valid}, 32'h0);

        // R6 synchronized pin levels
        pin_in = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        bus_op(1'b0, 8'h70, 32'h0);
        check("R6 ext level", rsp_rdata, 32'hDEAD_BEEF);
        pin_in = 32'h0000_0001;
        repeat (3) @(negedge clk);
        bus_op(1'b0, 8'h70, 32'h0);
        check("R6 ext level 2", rsp_rdata, 32'h0000_0001);

        // R1 / R2: pin 31 and pin 0 single-bit edits
        bus_op(1'b1, 8'h04, 32'h8000_0000);
        check("R2 clear pin31", pin_out, 32'h0000_A505);
        bus_op(1'b1, 8'h00, 32'h0001_0000);
        check("R1 clear pin0", pin_out, 32'h0000_A504);
        bus_op(1'b1, 8'h00, 32'h0000_FFFF);
        check("R1 zero enables no change", pin_out, 32'h0000_A504);

        // R9 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 pin_out after reset", pin_out, 32'h0);
        check("R9 pin_oe after reset", pin_oe, 32'h0);

        finish_run();
    end
endmodule